// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter for an 8-bit Microcontroller Core

This block gathers eleven interrupt sources around a small 8-bit microcontroller core and decides, every cycle, which of them the core should vector to next. The sources are two external pins, three timers, a serial receiver and transmitter, a power-supply monitor, a metering engine, a real-time clock, a serial SPI/I2C port and a watchdog. Each source has its own enable bit and a priority bit. A global enable gates the whole block. The power-supply source always sits alone on a third level, above the ordinary high level.

The arbiter presents a registered request with its vector address and priority level. The core answers with `ack` when it enters the service routine and with `reti` when it returns. The sources differ in how entry treats their flags. Some receive a one-cycle clear strobe. Some are left for software to clear. The external pins clear only in falling-edge mode. The clock and the SPI/I2C port keep a pending bit of their own, inside this block. A stack of in-service levels makes sure that only a strictly higher level can interrupt a running routine.

Top module: `irq_arbiter_top`

## Requirements
- R1: After reset, `irq_req` is 0, `svc_lvl` is 0 (nothing in service) and `clr_stb` is all zero.
- R2: Among eligible requests at the same level, the lowest source index wins. Index order: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 power, 7 metering, 8 clock, 9 SPI/I2C, 10 watchdog. Bit i of `src_en`, `prio_hi` and `clr_stb` belongs to index i.
- R3: `irq_vec` equals 0x03 + 8 × index, so ext0 is 0x03, timer2 is 0x2B, power is 0x33 and watchdog is 0x53.
- R4: A source's level code is 1 (low) when its `prio_hi` bit is 0 and 2 (high) when it is 1. The power source always has code 3, whatever its `prio_hi` bit. The highest eligible level wins over the polling order.
- R5: A source is eligible only if its level code is strictly greater than `svc_lvl`. An accepted `ack` marks the requested level as in service. `reti` removes the highest level in service. `svc_lvl` shows the highest level in service, or 0 when none is.
- R6: A source is eligible only while its `src_en` bit and `glob_en` are both 1. Pending requests survive while they are disabled. A request appears one clock after `glob_en` rises, and is gone one clock after `glob_en` falls.
- R7: With `ext_edge_mode[n]`=1, a falling edge on `ext_pin_n[n]` latches a flag that keeps requesting after the pin returns high. Entry clears the flag and pulses the matching `clr_stb` bit.
- R8: With `ext_edge_mode[n]`=0, the external source requests while its pin is low. Entry gives no clear strobe, and the source is taken again after `reti` for as long as the pin stays low.
- R9: The serial request is `uart_tx_flag | uart_rx_flag`, and the timer2 request is `t2_ovf_flag | t2_ext_flag`. Entry to serial, timer2, power, metering or watchdog gives no clear strobe, so the request returns after `reti` while the flags stay set.
- R10: Entry to timer0 or timer1 pulses `clr_stb` bit 1 or bit 3.
- R11: A one-cycle `rtc_evt` or `ser_evt` sets an internal pending bit. The bit holds while its enable is 0 and clears only on entry to its vector, which also pulses `clr_stb` bit 8 or bit 9.
- R12: A pulse on `ext_wake[n]` sets a pending wake request for external source n. The wake request holds while disabled and is cleared by entry.
- R13: The clock after an accepted `ack`, `irq_req` is 0. Any `clr_stb` pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | External interrupt pins, active low, already synchronised |
| ext_edge_mode | input | 2 | 1 selects falling-edge mode, 0 selects low-level mode, per pin |
| ext_wake | input | 2 | Wake-event pulse per external source |
| tmr_flag | input | 2 | Timer0 and timer1 overflow flags |
| uart_tx_flag | input | 1 | Serial transmit-done flag |
| uart_rx_flag | input | 1 | Serial receive-done flag |
| t2_ovf_flag | input | 1 | Timer2 overflow flag |
| t2_ext_flag | input | 1 | Timer2 external-event flag |
| psu_flag | input | 1 | Power-supply monitor flag |
| meas_flag | input | 1 | Metering engine flag |
| rtc_evt | input | 1 | Real-time clock event pulse |
| ser_evt | input | 1 | SPI/I2C port event pulse |
| wdog_flag | input | 1 | Watchdog flag |
| src_en | input | 11 | Per-source enable |
| prio_hi | input | 11 | Per-source high-priority select |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Core enters the requested vector |
| reti | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Vector request |
| irq_vec | output | 8 | Vector address of the request |
| irq_lvl | output | 2 | Level code of the request |
| svc_lvl | output | 2 | Highest level in service (0 = none) |
| clr_stb | output | 11 | One-cycle clear strobes back to the sources |

## Verification
The hardest state to reach from the ports is a stack three levels deep. A low-level routine has to be running when a high-level timer preempts it, and the power source must then preempt that routine as well, while a pending low-level request waits underneath. The bench builds this with a chain of acknowledges, setting each flag only after the level below it is in service. It then unwinds with single returns and checks `svc_lvl` after each one. The waiting request has to surface only after the last return. The latched clock and wake paths are reached by pulsing their events while the enable is off, letting several clocks pass, and only then setting the enable.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
    localparam int NSRC = 11;
    localparam int IDW  = $clog2(NSRC);
    localparam int NLVL = 3;
    localparam int LVLW = $clog2(NLVL + 1);
    localparam int VECW = 8;

    localparam logic [VECW-1:0] VEC_BASE = 8'h03;
    localparam logic [VECW-1:0] VEC_STEP = 8'h08;

    localparam logic [LVLW-1:0] LVL_NONE = 2'd0;
    localparam logic [LVLW-1:0] LVL_LOW  = 2'd1;
    localparam logic [LVLW-1:0] LVL_HIGH = 2'd2;
    localparam logic [LVLW-1:0] LVL_TOP  = 2'd3;

    // Index order is also the polling order inside a level.
    typedef enum logic [IDW-1:0] {
        SRC_EX0  = 4'd0,
        SRC_TM0  = 4'd1,
        SRC_EX1  = 4'd2,
        SRC_TM1  = 4'd3,
        SRC_UART = 4'd4,
        SRC_TM2  = 4'd5,
        SRC_PSU  = 4'd6,
        SRC_MEAS = 4'd7,
        SRC_RTC  = 4'd8,
        SRC_SER  = 4'd9,
        SRC_WDOG = 4'd10
    } src_e;

    function automatic logic [VECW-1:0] vec_of(input logic [IDW-1:0] id);
        return VEC_BASE + VEC_STEP * VECW'(id);
    endfunction
endpackage

// File: rtl/irq_src_latch.sv
`timescale 1ns/1ps
module irq_src_latch
    import irq_arb_pkg::*;
#(
    parameter int NEXT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_pin_n,
    input  logic [NEXT-1:0] ext_edge_mode,
    input  logic [NEXT-1:0] ext_wake,
    input  logic            rtc_evt,
    input  logic            ser_evt,
    input  logic            entry_vld,
    input  logic [IDW-1:0]  entry_id,
    output logic [NEXT-1:0] ext_req,
    output logic            rtc_pend,
    output logic            ser_pend
);
    typedef struct packed {
        logic [NEXT-1:0] pin;
        logic [NEXT-1:0] edge_f;
        logic [NEXT-1:0] wake;
        logic            rtc;
        logic            ser;
    } lat_t;

    lat_t q, d;
    logic [NEXT-1:0] ent_v;
    logic [NEXT-1:0] fall_v;
    logic            ent_rtc;
    logic            ent_ser;

    // External sources sit at the even indices 0 and 2.
    always_comb begin
        for (int e = 0; e < NEXT; e++) begin
            ent_v[e]  = entry_vld && (entry_id == IDW'(2 * e));
            fall_v[e] = q.pin[e] && !ext_pin_n[e];
        end
        ent_rtc = entry_vld && (entry_id == SRC_RTC);
        ent_ser = entry_vld && (entry_id == SRC_SER);
    end

    always_comb begin
        d     = q;
        d.pin = ext_pin_n;
        for (int e = 0; e < NEXT; e++) begin
            if (ext_edge_mode[e]) begin
                d.edge_f[e] = (q.edge_f[e] && !ent_v[e]) || fall_v[e];
            end
            d.wake[e] = (q.wake[e] && !ent_v[e]) || ext_wake[e];
        end
        d.rtc = (q.rtc && !ent_rtc) || rtc_evt;
        d.ser = (q.ser && !ent_ser) || ser_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pin    <= '1;
            q.edge_f <= '0;
            q.wake   <= '0;
            q.rtc    <= 1'b0;
            q.ser    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int e = 0; e < NEXT; e++) begin
            ext_req[e] = (ext_edge_mode[e] ? q.edge_f[e] : !ext_pin_n[e]) || q.wake[e];
        end
    end

    assign rtc_pend = q.rtc;
    assign ser_pend = q.ser;
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int N = 11,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/irq_svc_stack.sv
`timescale 1ns/1ps
module irq_svc_stack #(
    parameter int NL = 3,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [LW-1:0] push_lvl,
    input  logic          pop,
    output logic [LW-1:0] svc_lvl
);
    typedef struct packed {
        logic [NL-1:0] act;
    } stk_t;

    stk_t q, d;
    logic [LW-1:0] cur;

    always_comb begin
        cur = '0;
        for (int k = 0; k < NL; k++) begin
            if (q.act[k]) cur = LW'(k + 1);
        end
    end

    always_comb begin
        d = q;
        if (pop && cur != '0) d.act[cur - 1'b1] = 1'b0;
        if (push && push_lvl != '0) d.act[push_lvl - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.act <= '0;
        else        q <= d;
    end

    assign svc_lvl = cur;
endmodule

// File: rtl/irq_arbiter_top.sv
`timescale 1ns/1ps
module irq_arbiter_top
    import irq_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ext_pin_n,
    input  logic [1:0]      ext_edge_mode,
    input  logic [1:0]      ext_wake,
    input  logic [1:0]      tmr_flag,
    input  logic            uart_tx_flag,
    input  logic            uart_rx_flag,
    input  logic            t2_ovf_flag,
    input  logic            t2_ext_flag,
    input  logic            psu_flag,
    input  logic            meas_flag,
    input  logic            rtc_evt,
    input  logic            ser_evt,
    input  logic            wdog_flag,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] prio_hi,
    input  logic            glob_en,
    input  logic            ack,
    input  logic            reti,
    output logic            irq_req,
    output logic [VECW-1:0] irq_vec,
    output logic [LVLW-1:0] irq_lvl,
    output logic [LVLW-1:0] svc_lvl,
    output logic [NSRC-1:0] clr_stb
);
    typedef struct packed {
        logic            req;
        logic [IDW-1:0]  id;
        logic [VECW-1:0] vec;
        logic [LVLW-1:0] lvl;
        logic [NSRC-1:0] clr;
    } arb_t;

    arb_t q, d;

    logic            entry;
    logic [1:0]      ext_req;
    logic            rtc_pend;
    logic            ser_pend;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] elig;
    logic [LVLW-1:0] src_lvl [NSRC];
    logic [NLVL-1:0] lvl_hit;
    logic [IDW-1:0]  lvl_idx [NLVL];
    logic            win_hit;
    logic [IDW-1:0]  win_id;
    logic [LVLW-1:0] win_lvl;
    logic [NSRC-1:0] clr_mask;

    assign entry = ack && q.req;

    irq_src_latch #(.NEXT(2)) u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_pin_n     (ext_pin_n),
        .ext_edge_mode (ext_edge_mode),
        .ext_wake      (ext_wake),
        .rtc_evt       (rtc_evt),
        .ser_evt       (ser_evt),
        .entry_vld     (entry),
        .entry_id      (q.id),
        .ext_req       (ext_req),
        .rtc_pend      (rtc_pend),
        .ser_pend      (ser_pend)
    );

    irq_svc_stack #(.NL(NLVL), .LW(LVLW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (entry),
        .push_lvl (q.lvl),
        .pop      (reti),
        .svc_lvl  (svc_lvl)
    );

    // Raw request per source, in index order.
    always_comb begin
        raw           = '0;
        raw[SRC_EX0]  = ext_req[0];
        raw[SRC_TM0]  = tmr_flag[0];
        raw[SRC_EX1]  = ext_req[1];
        raw[SRC_TM1]  = tmr_flag[1];
        raw[SRC_UART] = uart_tx_flag || uart_rx_flag;
        raw[SRC_TM2]  = t2_ovf_flag || t2_ext_flag;
        raw[SRC_PSU]  = psu_flag;
        raw[SRC_MEAS] = meas_flag;
        raw[SRC_RTC]  = rtc_pend;
        raw[SRC_SER]  = ser_pend;
        raw[SRC_WDOG] = wdog_flag;
    end

    // Level per source; the power source is pinned to the top level.
    for (genvar i = 0; i < NSRC; i++) begin : g_lvl_map
        if (i == int'(SRC_PSU)) begin : g_top
            // OR into an all-ones code: the select bit has no effect here.
            assign src_lvl[i] = LVL_TOP | {1'b0, prio_hi[i]};
        end else begin : g_sel
            assign src_lvl[i] = prio_hi[i] ? LVL_HIGH : LVL_LOW;
        end
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = raw[i] && src_en[i] && glob_en && (src_lvl[i] > svc_lvl);
        end
    end

    for (genvar L = 0; L < NLVL; L++) begin : g_level
        logic [NSRC-1:0] mask;
        always_comb begin
            for (int i = 0; i < NSRC; i++) begin
                mask[i] = elig[i] && (src_lvl[i] == LVLW'(L + 1));
            end
        end
        irq_prio_pick #(.N(NSRC), .W(IDW)) u_pick (
            .req (mask),
            .hit (lvl_hit[L]),
            .idx (lvl_idx[L])
        );
    end

    always_comb begin
        win_hit = 1'b0;
        win_id  = '0;
        win_lvl = LVL_NONE;
        for (int L = 0; L < NLVL; L++) begin
            if (lvl_hit[L]) begin
                win_hit = 1'b1;
                win_id  = lvl_idx[L];
                win_lvl = LVLW'(L + 1);
            end
        end
    end

    // Which sources receive a hardware clear on entry.
    always_comb begin
        clr_mask = '0;
        case (q.id)
            SRC_EX0:  clr_mask[SRC_EX0] = ext_edge_mode[0];
            SRC_EX1:  clr_mask[SRC_EX1] = ext_edge_mode[1];
            SRC_TM0,
            SRC_TM1,
            SRC_RTC,
            SRC_SER:  clr_mask[q.id] = 1'b1;
            default:  clr_mask = '0;
        endcase
    end

    always_comb begin
        d     = q;
        d.clr = '0;
        if (entry) begin
            d.req = 1'b0;
            d.clr = clr_mask;
        end else begin
            d.req = win_hit;
            d.id  = win_id;
            d.vec = vec_of(win_id);
            d.lvl = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.req <= 1'b0;
            q.id  <= '0;
            q.vec <= '0;
            q.lvl <= LVL_NONE;
            q.clr <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_req = q.req;
    assign irq_vec = q.vec;
    assign irq_lvl = q.lvl;
    assign clr_stb = q.clr;
endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            glob_en,
    input logic            ack,
    input logic            reti,
    input logic            irq_req,
    input logic [VECW-1:0] irq_vec,
    input logic [LVLW-1:0] irq_lvl,
    input logic [LVLW-1:0] svc_lvl,
    input logic [NSRC-1:0] clr_stb
);
    a_r13_drop_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> !irq_req);

    a_r13_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_stb) |=> (clr_stb == '0));

    a_r5_push_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !reti) |=> (svc_lvl == $past(irq_lvl)));

    a_r5_req_above_svc: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > svc_lvl));

    a_r6_glob_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq_req);

    a_r4_power_top: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vec == 8'h33) |-> (irq_lvl == LVL_TOP));

    a_r3_vec_align: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011));
endmodule

bind irq_arbiter_top irq_arbiter_chk chk_i (.*);

// File: tb/irq_arbiter_top_tb.sv
`timescale 1ns/1ps
module irq_arbiter_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n, ext_edge_mode, ext_wake, tmr_flag;
    logic        uart_tx_flag, uart_rx_flag, t2_ovf_flag, t2_ext_flag;
    logic        psu_flag, meas_flag, rtc_evt, ser_evt, wdog_flag;
    logic [10:0] src_en, prio_hi;
    logic        glob_en, ack, reti;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic [1:0]  irq_lvl, svc_lvl;
    logic [10:0] clr_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_arbiter_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
        .ext_wake(ext_wake), .tmr_flag(tmr_flag), .uart_tx_flag(uart_tx_flag),
        .uart_rx_flag(uart_rx_flag), .t2_ovf_flag(t2_ovf_flag), .t2_ext_flag(t2_ext_flag),
        .psu_flag(psu_flag), .meas_flag(meas_flag), .rtc_evt(rtc_evt), .ser_evt(ser_evt),
        .wdog_flag(wdog_flag), .src_en(src_en), .prio_hi(prio_hi), .glob_en(glob_en),
        .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .svc_lvl(svc_lvl), .clr_stb(clr_stb)
    );

    typedef struct packed {
        logic [10:0] f;
        logic [10:0] en;
        logic [10:0] hi;
        logic        g;
        logic        req;
        logic [7:0]  vec;
        logic [1:0]  lvl;
    } vec_t;

    // f bits: 1 timer0, 3 timer1, 4 serial tx, 5 timer2 ovf, 6 power, 7 metering, 10 watchdog
    localparam vec_t TBL [12] = '{
        '{11'h002, 11'h7FF, 11'h000, 1'b1, 1'b1, 8'h0B, 2'd1},  // R2 R3 single
        '{11'h00A, 11'h7FF, 11'h008, 1'b1, 1'b1, 8'h1B, 2'd2},  // R4 high beats order
        '{11'h412, 11'h7FF, 11'h000, 1'b1, 1'b1, 8'h0B, 2'd1},  // R2 order
        '{11'h0B0, 11'h7FF, 11'h000, 1'b1, 1'b1, 8'h23, 2'd1},  // R2 order
        '{11'h042, 11'h7FF, 11'h002, 1'b1, 1'b1, 8'h33, 2'd3},  // R4 power on top
        '{11'h002, 11'h7FF, 11'h000, 1'b0, 1'b0, 8'h00, 2'd0},  // R6 global off
        '{11'h00A, 11'h008, 11'h000, 1'b1, 1'b1, 8'h1B, 2'd1},  // R6 source enable
        '{11'h480, 11'h7FF, 11'h400, 1'b1, 1'b1, 8'h53, 2'd2},  // R4 R3 watchdog high
        '{11'h000, 11'h7FF, 11'h000, 1'b1, 1'b0, 8'h00, 2'd0},  // R2 idle
        '{11'h040, 11'h7BF, 11'h000, 1'b1, 1'b0, 8'h00, 2'd0},  // R6 power disabled
        '{11'h0A0, 11'h7FF, 11'h000, 1'b1, 1'b1, 8'h2B, 2'd1},  // R2 timer2 first
        '{11'h490, 11'h7FF, 11'h480, 1'b1, 1'b1, 8'h3B, 2'd2}   // R2 order inside high
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic idle();
        ext_pin_n = 2'b11; ext_edge_mode = 2'b11; ext_wake = 2'b00; tmr_flag = 2'b00;
        uart_tx_flag = 0; uart_rx_flag = 0; t2_ovf_flag = 0; t2_ext_flag = 0;
        psu_flag = 0; meas_flag = 0; rtc_evt = 0; ser_evt = 0; wdog_flag = 0;
        src_en = 11'h7FF; prio_hi = 11'h000; glob_en = 1'b1; ack = 1'b0; reti = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL R13 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle();
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 irq_req after reset", irq_req, 0);
        chk("R1 svc_lvl after reset", svc_lvl, 0);
        chk("R1 clr_stb after reset", clr_stb, 0);

        // Table walk: arbitration with nothing in service.
        for (int k = 0; k < 12; k++) begin
            tmr_flag     = {TBL[k].f[3], TBL[k].f[1]};
            uart_tx_flag = TBL[k].f[4];
            t2_ovf_flag  = TBL[k].f[5];
            psu_flag     = TBL[k].f[6];
            meas_flag    = TBL[k].f[7];
            wdog_flag    = TBL[k].f[10];
            src_en = TBL[k].en; prio_hi = TBL[k].hi; glob_en = TBL[k].g;
            tick(1);
            chk($sformatf("R2/R4/R6 row %0d req", k), irq_req, TBL[k].req);
            if (TBL[k].req) begin
                chk($sformatf("R3 row %0d vec", k), irq_vec, TBL[k].vec);
                chk($sformatf("R4 row %0d lvl", k), irq_lvl, TBL[k].lvl);
            end
        end
        idle();
        tick(2);

        // R5 R10 R13: nesting three levels deep.
        tmr_flag[0] = 1'b1;
        tick(1);
        chk("R10 timer0 vec", irq_vec, 8'h0B);
        do_ack();
        chk("R10 timer0 strobe", clr_stb, 11'h002);
        chk("R5 svc after low entry", svc_lvl, 1);
        chk("R13 req drops after entry", irq_req, 0);
        tmr_flag[0] = 1'b0;
        tick(1);
        chk("R13 strobe single cycle", clr_stb, 0);
        uart_tx_flag = 1'b1;
        tick(2);
        chk("R5 equal level blocked", irq_req, 0);
        prio_hi[3] = 1'b1; tmr_flag[1] = 1'b1;
        tick(2);
        chk("R5 high preempts low", irq_vec, 8'h1B);
        chk("R5 high preempt lvl", irq_lvl, 2);
        do_ack();
        chk("R10 timer1 strobe", clr_stb, 11'h008);
        chk("R5 svc after high entry", svc_lvl, 2);
        tmr_flag[1] = 1'b0;
        psu_flag = 1'b1;
        tick(2);
        chk("R4 power preempts high", irq_req, 1);
        chk("R4 power vec", irq_vec, 8'h33);
        do_ack();
        chk("R9 power no strobe", clr_stb, 0);
        chk("R5 svc at top", svc_lvl, 3);
        psu_flag = 1'b0;
        do_reti();
        chk("R5 pop to high", svc_lvl, 2);
        do_reti();
        chk("R5 pop to low", svc_lvl, 1);
        tick(1);
        chk("R5 low still blocked", irq_req, 0);
        do_reti();
        chk("R5 stack empty", svc_lvl, 0);
        tick(1);
        chk("R5 waiting serial taken", irq_vec, 8'h23);
        chk("R5 waiting serial req", irq_req, 1);
        uart_tx_flag = 1'b0;
        tick(2);
        prio_hi = 11'h000;

        // R9: serial via rx only, not cleared, returns after reti.
        uart_rx_flag = 1'b1;
        tick(1);
        chk("R9 serial rx vec", irq_vec, 8'h23);
        do_ack();
        chk("R9 serial no strobe", clr_stb, 0);
        do_reti();
        tick(1);
        chk("R9 serial re-request", irq_req, 1);
        chk("R9 serial re-request vec", irq_vec, 8'h23);
        uart_rx_flag = 1'b0;
        t2_ext_flag = 1'b1;
        tick(2);
        chk("R9 timer2 external flag vec", irq_vec, 8'h2B);
        t2_ext_flag = 1'b0;
        tick(2);

        // R7: edge mode on ext0.
        ext_pin_n[0] = 1'b0;
        tick(1);
        ext_pin_n[0] = 1'b1;
        tick(2);
        chk("R7 edge latched", irq_req, 1);
        chk("R7 edge vec", irq_vec, 8'h03);
        do_ack();
        chk("R7 edge strobe", clr_stb, 11'h001);
        do_reti();
        tick(1);
        chk("R7 flag cleared by entry", irq_req, 0);

        // R8: level mode on ext1.
        ext_edge_mode[1] = 1'b0;
        ext_pin_n[1] = 1'b0;
        tick(2);
        chk("R8 level vec", irq_vec, 8'h13);
        do_ack();
        chk("R8 level no strobe", clr_stb, 0);
        do_reti();
        tick(1);
        chk("R8 level re-entered", irq_req, 1);
        do_ack();
        ext_pin_n[1] = 1'b1;
        do_reti();
        tick(1);
        chk("R8 pin high ends request", irq_req, 0);
        chk("R8 stack empty", svc_lvl, 0);
        ext_edge_mode[1] = 1'b1;
        tick(1);

        // R11: clock pending survives disable.
        src_en[8] = 1'b0;
        rtc_evt = 1'b1;
        tick(1);
        rtc_evt = 1'b0;
        tick(3);
        chk("R11 disabled clock silent", irq_req, 0);
        src_en[8] = 1'b1;
        tick(1);
        chk("R11 clock pending kept", irq_vec, 8'h43);
        chk("R11 clock req", irq_req, 1);
        do_ack();
        chk("R11 clock strobe", clr_stb, 11'h100);
        do_reti();
        tick(1);
        chk("R11 clock cleared by entry", irq_req, 0);
        ser_evt = 1'b1;
        tick(1);
        ser_evt = 1'b0;
        tick(1);
        chk("R11 spi/i2c vec", irq_vec, 8'h4B);
        do_ack();
        chk("R11 spi/i2c strobe", clr_stb, 11'h200);
        do_reti();
        tick(1);
        chk("R11 spi/i2c cleared", irq_req, 0);

        // R12: wake event held until enabled.
        src_en[0] = 1'b0;
        ext_wake[0] = 1'b1;
        tick(1);
        ext_wake[0] = 1'b0;
        tick(3);
        chk("R12 wake silent while disabled", irq_req, 0);
        src_en[0] = 1'b1;
        tick(1);
        chk("R12 wake vectored", irq_vec, 8'h03);
        chk("R12 wake req", irq_req, 1);
        do_ack();
        do_reti();
        tick(1);
        chk("R12 wake cleared by entry", irq_req, 0);

        // R6: request on the first clock after global enable rises.
        glob_en = 1'b0;
        tmr_flag[0] = 1'b1;
        tick(3);
        chk("R6 held off by global", irq_req, 0);
        glob_en = 1'b1;
        tick(1);
        chk("R6 first cycle after enable", irq_req, 1);
        chk("R6 vec after enable", irq_vec, 8'h0B);
        tmr_flag[0] = 1'b0;
        tick(2);

        finish_run();
    end
endmodule